// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative translation cache. Every entry is tagged with a 12-bit address-space identifier, so several processes can share one cache without a flush between them, even when they use the same virtual addresses. The tag is folded into the match key. The page-aligned virtual address has its 12 offset bits cleared, and the active identifier is placed in those low bits. When the context-enable input is low, the active identifier is zero, whatever value sits on the identifier input.

A lookup is combinational. It returns a hit flag, the translated physical address, and the read-only and uncacheable flags of the matching entry. A page walker writes new translations through the fill port on the clock edge. A fill is tagged with the identifier that is active in that cycle. A fill whose key already matches a stored entry is dropped. Otherwise the fill takes a free slot, or it evicts the least recently used entry. Entries can map 4 KiB, 2 MiB or 1 GiB pages. A large-page entry compares only the key bits above its page size, so it matches under any identifier. A single flush input invalidates the whole cache.

Top module: `ctx_tagged_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: The active identifier is `ctx_id` when `ctx_en` is 1, and it is 0 when `ctx_en` is 0. Lookups and fills both use this same rule.
- R3: A 4 KiB entry hits only when the lookup virtual address bits [47:12] and the active identifier both equal the values stored at fill time. The lookup address bits [11:0] are free.
- R4: Size codes are 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB, and 3 is handled as 4 KiB. On a hit the physical address is {frame, 12'b0}. Its low 12, 21 or 30 bits, chosen by the entry's size code, are replaced by the same bits of the lookup virtual address.
- R5: A 2 MiB or 1 GiB entry compares only key bits [47:21] or [47:30] respectively. It therefore matches under any active identifier.
- R6: A fill is tagged with the identifier that is active in its own cycle.
- R7: A fill whose key matches a valid entry changes nothing: later lookups still return the original frame and flags.
- R8: When no slot is free, a fill replaces the entry that was least recently written or hit. A lookup hit counts as a use.
- R9: `flush_all` invalidates every entry by the next cycle, and it wins over a fill in the same cycle.
- R10: The hit entry's flags appear on `lk_ro` and `lk_nc`. On a miss, `lk_paddr`, `lk_ro` and `lk_nc` are all 0.
- R11: With `lk_valid` low, `lk_hit` is 0 and no use is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate all entries |
| ctx_en | input | 1 | Enables identifier tagging |
| ctx_id | input | 12 | Current address-space identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 52 | Translated physical address |
| lk_ro | output | 1 | Read-only flag of hit entry |
| lk_nc | output | 1 | Uncacheable flag of hit entry |
| fill_en | input | 1 | Fill request |
| fill_vpn | input | 36 | Virtual page number to fill |
| fill_pfn | input | 40 | Physical frame number |
| fill_size | input | 2 | Page-size code |
| fill_ro | input | 1 | Read-only flag |
| fill_nc | input | 1 | Uncacheable flag |

## Verification
A corrupted key, size code or valid bit shows up at the ports on the first lookup that targets that entry, because the lookup path is combinational. It appears as a hit that should be a miss, or as a wrong physical address. A corrupted use stamp causes no visible fault until the cache is full and a fill evicts the wrong entry. The damage then shows as an unexpected miss on a later lookup. The reference model in the bench is therefore compared on every cycle, and directed sequences fill the cache to capacity before probing the eviction order.

// File: rtl/ctx_tagged_tlb.sv
module ctx_tagged_tlb #(
  parameter int N         = 16,
  parameter int VA_W      = 48,
  parameter int PFN_W     = 40,
  parameter int CTX_W     = 12,
  parameter int STAMP_W   = 32,
  parameter bit VAR_PAGES = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_all,
  input  logic                   ctx_en,
  input  logic [CTX_W-1:0]       ctx_id,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   lk_hit,
  output logic [PFN_W+CTX_W-1:0] lk_paddr,
  output logic                   lk_ro,
  output logic                   lk_nc,
  input  logic                   fill_en,
  input  logic [VA_W-CTX_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [1:0]             fill_size,
  input  logic                   fill_ro,
  input  logic                   fill_nc
);
  localparam int PA_W  = PFN_W + CTX_W;
  localparam int IDX_W = $clog2(N);
  localparam int LG_M  = 21;
  localparam int LG_G  = 30;

  function automatic logic [VA_W-1:0] key_mask(input logic [1:0] sz);
    if (!VAR_PAGES) return '1;
    case (sz)
      2'd1:    return {VA_W{1'b1}} << LG_M;
      2'd2:    return {VA_W{1'b1}} << LG_G;
      default: return '1;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] off_mask(input logic [1:0] sz);
    case (sz)
      2'd1:    return (PA_W'(1) << LG_M) - PA_W'(1);
      2'd2:    return (PA_W'(1) << LG_G) - PA_W'(1);
      default: return (PA_W'(1) << CTX_W) - PA_W'(1);
    endcase
  endfunction

  logic [N-1:0]       vld;
  logic [VA_W-1:0]    key_q   [N];
  logic [PFN_W-1:0]   pfn_q   [N];
  logic [1:0]         sz_q    [N];
  logic               ro_q    [N];
  logic               nc_q    [N];
  logic [STAMP_W-1:0] stamp_q [N];
  logic [STAMP_W-1:0] seq_q;

  logic [CTX_W-1:0] act_ctx;
  logic [VA_W-1:0]  lk_key, fill_key;
  logic [N-1:0]     lk_m, fl_m;
  logic [IDX_W-1:0] hidx, vic;
  logic             have_free, fill_do;
  logic [PA_W-1:0]  om;

  assign act_ctx  = ctx_en ? ctx_id : '0;
  assign lk_key   = {lk_vaddr[VA_W-1:CTX_W], act_ctx};
  assign fill_key = {fill_vpn, act_ctx};

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lk_m[i] = vld[i] && (((key_q[i] ^ lk_key)   & key_mask(sz_q[i])) == '0);
    assign fl_m[i] = vld[i] && (((key_q[i] ^ fill_key) & key_mask(sz_q[i])) == '0);
  end

  always_comb begin
    hidx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (lk_m[i]) hidx = IDX_W'(i);
  end

  always_comb begin
    vic = '0;
    have_free = 1'b0;
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) begin
        vic = IDX_W'(i);
        have_free = 1'b1;
      end
    if (!have_free)
      for (int i = 1; i < N; i++)
        if (stamp_q[i] < stamp_q[vic]) vic = IDX_W'(i);
  end

  assign lk_hit   = lk_valid && (|lk_m);
  assign om       = off_mask(sz_q[hidx]);
  assign lk_paddr = lk_hit ? (({pfn_q[hidx], {CTX_W{1'b0}}} & ~om) | (PA_W'(lk_vaddr) & om)) : '0;
  assign lk_ro    = lk_hit && ro_q[hidx];
  assign lk_nc    = lk_hit && nc_q[hidx];
  assign fill_do  = fill_en && !flush_all && !(|fl_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      seq_q <= '0;
    end else begin
      seq_q <= seq_q + STAMP_W'(lk_hit) + STAMP_W'(fill_do);
      if (flush_all)    vld      <= '0;
      else if (fill_do) vld[vic] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_hit) stamp_q[hidx] <= seq_q;
    if (fill_do) begin
      key_q[vic]   <= fill_key;
      pfn_q[vic]   <= fill_pfn;
      sz_q[vic]    <= fill_size;
      ro_q[vic]    <= fill_ro;
      nc_q[vic]    <= fill_nc;
      stamp_q[vic] <= seq_q + STAMP_W'(lk_hit);
    end
  end
endmodule

// File: rtl/ctx_tagged_tlb_chk.sv
module ctx_tagged_tlb_chk #(
  parameter int N     = 16,
  parameter int VA_W  = 48,
  parameter int PFN_W = 40,
  parameter int CTX_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush_all,
  input logic                   fill_en,
  input logic                   ctx_en,
  input logic [CTX_W-1:0]       ctx_id,
  input logic                   lk_valid,
  input logic [VA_W-1:0]        lk_vaddr,
  input logic                   lk_hit,
  input logic [PFN_W+CTX_W-1:0] lk_paddr,
  input logic                   lk_ro,
  input logic                   lk_nc,
  input logic [N-1:0]           vld
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) $rose(rst_n) |-> (vld == '0));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0));

  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && !lk_ro && !lk_nc));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[CTX_W-1:0] == lk_vaddr[CTX_W-1:0]));

  // R11
  idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  // R3
  hit_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_hit) && !$past(fill_en) && !$past(flush_all) && lk_valid &&
     $stable(lk_vaddr) && $stable(ctx_en) && $stable(ctx_id))
    |-> (lk_hit && $stable(lk_paddr)));
endmodule

bind ctx_tagged_tlb ctx_tagged_tlb_chk #(.N(N), .VA_W(VA_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) chk_i (.*);

// File: tb/ctx_tagged_tlb_test.sv
`timescale 1ns/1ps
module ctx_tagged_tlb_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush_all = 0, ctx_en = 0, lk_valid = 0, fill_en = 0, fill_ro = 0, fill_nc = 0;
  logic [11:0] ctx_id = 0;
  logic [47:0] lk_vaddr = 0;
  logic [35:0] fill_vpn = 0;
  logic [39:0] fill_pfn = 0;
  logic [1:0]  fill_size = 0;
  logic        lk_hit, lk_ro, lk_nc;
  logic [51:0] lk_paddr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_tagged_tlb uut (.*);

  bit          m_valid [16];
  logic [47:0] m_key   [16];
  logic [39:0] m_pfn   [16];
  int          m_size  [16];
  bit          m_ro    [16], m_nc [16];
  longint      m_stamp [16];
  longint      m_seq = 0;

  bit e_hit, e_ro, e_nc; logic [51:0] e_pa; int e_idx;
  bit o_hit, o_ro, o_nc; logic [51:0] o_pa;

  function automatic int span(int sz);
    return sz == 1 ? 21 : (sz == 2 ? 30 : 12);
  endfunction

  function automatic bit mmatch(int i, logic [47:0] k);
    int sh = (m_size[i] == 1) ? 21 : ((m_size[i] == 2) ? 30 : 0);
    return m_valid[i] && ((m_key[i] >> sh) == (k >> sh));
  endfunction

  function automatic logic [11:0] actv();
    return ctx_en ? ctx_id : 12'h0;
  endfunction

  task automatic model_lookup();
    logic [47:0] k = {lk_vaddr[47:12], actv()};
    e_hit = 0; e_pa = 0; e_ro = 0; e_nc = 0; e_idx = -1;
    if (lk_valid)
      for (int i = 0; i < 16; i++)
        if (e_idx < 0 && mmatch(i, k)) e_idx = i;
    if (e_idx >= 0) begin
      int ob = span(m_size[e_idx]);
      logic [51:0] base = {m_pfn[e_idx], 12'h0};
      e_hit = 1;
      e_pa = ((base >> ob) << ob) | (52'(lk_vaddr) & ((52'd1 << ob) - 52'd1));
      e_ro = m_ro[e_idx]; e_nc = m_nc[e_idx];
    end
  endtask

  task automatic model_update();
    logic [47:0] fk = {fill_vpn, actv()};
    bit dup = 0; int vic = -1;
    for (int i = 0; i < 16; i++) if (mmatch(i, fk)) dup = 1;
    for (int i = 0; i < 16; i++) if (vic < 0 && !m_valid[i]) vic = i;
    if (vic < 0) begin
      vic = 0;
      for (int i = 1; i < 16; i++) if (m_stamp[i] < m_stamp[vic]) vic = i;
    end
    if (e_hit) begin m_stamp[e_idx] = m_seq; m_seq++; end
    if (flush_all) begin
      for (int i = 0; i < 16; i++) m_valid[i] = 0;
    end else if (fill_en && !dup) begin
      m_valid[vic] = 1; m_key[vic] = fk; m_pfn[vic] = fill_pfn;
      m_size[vic] = int'(fill_size); m_ro[vic] = fill_ro; m_nc[vic] = fill_nc;
      m_stamp[vic] = m_seq; m_seq++;
    end
  endtask

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle_compare();
    #1;
    model_lookup();
    o_hit = lk_hit; o_pa = lk_paddr; o_ro = lk_ro; o_nc = lk_nc;
    check("R3 model", {9'b0, o_hit, o_ro, o_nc, o_pa}, {9'b0, e_hit, e_ro, e_nc, e_pa});
    @(posedge clk);
    if (rst_n) model_update();
  endtask

  task automatic idle();
    fill_en = 0; lk_valid = 0; flush_all = 0;
  endtask

  task automatic do_fill(logic [47:0] va, logic [39:0] pfn, logic [1:0] sz, bit ro, bit nc,
                         bit ce, logic [11:0] cid, bit fl = 0);
    @(negedge clk);
    idle();
    fill_en = 1; fill_vpn = va[47:12]; fill_pfn = pfn; fill_size = sz;
    fill_ro = ro; fill_nc = nc; ctx_en = ce; ctx_id = cid; flush_all = fl;
    settle_compare();
  endtask

  task automatic do_look(logic [47:0] va, bit ce, logic [11:0] cid, bit lv = 1);
    @(negedge clk);
    idle();
    lk_valid = lv; lk_vaddr = va; ctx_en = ce; ctx_id = cid;
    settle_compare();
  endtask

  task automatic expect_look(string tag, bit hit, logic [51:0] pa, bit ro, bit nc);
    check(tag, {o_hit, o_ro, o_nc}, {hit, ro, nc});
    check(tag, 64'(o_pa), 64'(pa));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    do_look(48'h1234_5678_9ABC, 1, 12'h05A);
    expect_look("R1", 0, 0, 0, 0);

    do_fill(48'h0000_1234_5000, 40'hAB_CDEF_0123, 0, 1, 0, 1, 12'h05A);
    do_look(48'h0000_1234_5ABC, 1, 12'h05A);
    expect_look("R6 R10", 1, 52'hABCDEF0123ABC, 1, 0);
    do_look(48'h0000_1234_5ABC, 1, 12'h05B);
    expect_look("R3", 0, 0, 0, 0);
    do_look(48'h0000_1234_5ABC, 0, 12'h05A);
    expect_look("R2", 0, 0, 0, 0);

    do_fill(48'h0000_1234_5000, 40'h11, 0, 0, 1, 0, 12'h077);
    do_look(48'h0000_1234_5ABC, 0, 12'h099);
    expect_look("R2", 1, 52'h0000000011ABC, 0, 1);

    do_fill(48'h0000_1234_5FFF, 40'h22, 0, 0, 0, 1, 12'h05A);
    do_look(48'h0000_1234_5ABC, 1, 12'h05A);
    expect_look("R7", 1, 52'hABCDEF0123ABC, 1, 0);

    do_fill(48'h0000_4020_0000, 40'h400, 1, 0, 0, 1, 12'h005);
    do_look(48'h0000_403F_F123, 1, 12'h0C8);
    expect_look("R5 R4", 1, 52'h00000005FF123, 0, 0);
    do_look(48'h0000_4040_0000, 1, 12'h005);
    expect_look("R5", 0, 0, 0, 0);

    do_fill(48'h0080_4000_0000, 40'hC0000, 2, 1, 1, 1, 12'h003);
    do_look(48'h0080_7FFF_FFFF, 1, 12'h111);
    expect_look("R4", 1, 52'h00000FFFFFFFF, 1, 1);

    do_fill(48'h0000_0000_7000, 40'h55, 3, 0, 0, 0, 12'h0);
    do_look(48'h0000_0000_7010, 0, 12'h0);
    expect_look("R4", 1, 52'h0000000055010, 0, 0);
    do_look(48'h0000_0000_6010, 0, 12'h0);
    expect_look("R4", 0, 0, 0, 0);

    do_look(48'h0000_0000_7010, 0, 12'h0, 0);
    expect_look("R11", 0, 0, 0, 0);

    do_fill(48'h0000_0000_9000, 40'h66, 0, 0, 0, 0, 12'h0, 1);
    do_look(48'h0000_1234_5ABC, 1, 12'h05A);
    expect_look("R9", 0, 0, 0, 0);
    do_look(48'h0000_0000_9000, 0, 12'h0);
    expect_look("R9", 0, 0, 0, 0);

    for (int i = 0; i < 16; i++)
      do_fill(48'((i + 1) << 12), 40'(32'h100 + i), 0, 0, 0, 0, 12'h0);
    do_look(48'h1000, 0, 12'h0);
    expect_look("R8", 1, 52'h100000, 0, 0);
    do_fill(48'h40000, 40'h200, 0, 0, 0, 0, 12'h0);
    do_look(48'h2000, 0, 12'h0);
    expect_look("R8", 0, 0, 0, 0);
    do_look(48'h1000, 0, 12'h0);
    expect_look("R8", 1, 52'h100000, 0, 0);
    do_look(48'h3000, 0, 12'h0);
    expect_look("R8", 1, 52'h102000, 0, 0);
    do_look(48'h40000, 0, 12'h0);
    expect_look("R8", 1, 52'h200000, 0, 0);
    do_fill(48'h50000, 40'h300, 0, 0, 0, 0, 12'h0);
    do_look(48'h4000, 0, 12'h0);
    expect_look("R8", 0, 0, 0, 0);
    do_look(48'h5000, 0, 12'h0);
    expect_look("R8", 1, 52'h104000, 0, 0);

    for (int c = 0; c < 4000; c++) begin
      int op = int'($urandom % 16);
      logic [47:0] va = {26'h0, 10'($urandom % 1024), 12'($urandom)};
      if ($urandom % 8 == 0) va[31:30] = 2'($urandom);
      @(negedge clk);
      idle();
      ctx_en = 1'($urandom); ctx_id = 12'($urandom % 3);
      lk_valid = 1'($urandom % 4 != 0); lk_vaddr = va;
      fill_en = (op < 5);
      fill_vpn = {26'h0, 10'($urandom % 1024)};
      fill_pfn = 40'($urandom); fill_size = 2'($urandom);
      fill_ro = 1'($urandom); fill_nc = 1'($urandom);
      flush_all = (op == 15) && ($urandom % 4 == 0);
      settle_compare();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule